// File: doc/BRIEF.md
# Timing-Reference Interrupt Event Controller

This block sits beside a clock-synchronization core and turns its status lines into eight sticky event flags. Each flag is set by a transition on those lines: a reference dropping out or returning, the external reference losing or regaining activity, a change in the mode/alarm status word, an active-reference switch under automatic selection, a rising loss-of-signal or a rising loss-of-lock. One reference switch raises several flags in the same cycle, so software can tell from a single read why the core moved. Examples are loss of signal with a switch, or a higher-priority reference returning with a switch.

A parallel register port reaches three registers. The first is a read-only live status word. The second is the event register, and any read of it clears all eight flags. The third is a read/write enable mask. The active-high interrupt pin is the registered OR of every flag that is both set and enabled. In manual selection mode no switch event is possible. The loss-of-signal and loss-of-lock flags also stay set for as long as the matching alarm is present, so a read cannot clear them while the alarm persists.

Top module: `tref_irq_ctrl`

## Requirements
- R1: After reset all event flags, the enable mask and `irq` are zero. During the first clock after reset the block only samples its inputs, so inputs that are already nonzero raise no flag.
- R2: Event bit 0 is set when any `ref_avail` bit falls from 1 to 0. Event bit 1 is set when any `ref_avail` bit rises from 0 to 1.
- R3: Event bit 2 is set when `xref_active` falls. Event bit 3 is set when `xref_active` rises.
- R4: Event bit 4 is set when any of `los`, `lol`, `dpll_mode` or `active_ref` changes value.
- R5: When `auto_sel` is 1 and `active_ref` changes, bits 5 and 4 are set together. When `auto_sel` is 0, a change of `active_ref` never sets bit 5.
- R6: A rising `los` sets bit 6 and a rising `lol` sets bit 7. When such a rise comes with a switch, all cause bits appear in one read. This includes bit 1 when a reference returns in the same cycle as the switch.
- R7: When `auto_sel` is 0, bit 6 is set again on every clock while `los` is 1, and bit 7 on every clock while `lol` is 1. A read therefore leaves them set while the alarm persists.
- R8: Event flags latch and read back whatever their enable bit is. The enable mask at address 0x13 reads back the last value written to it. A flag whose enable bit is 0 never raises `irq`.
- R9: A read of address 0x12 returns the flags as they stood before that clock and clears all eight flags. An event detected in the same clock as the clearing read stays set.
- R10: `irq` is 1 exactly when, one clock earlier, some event flag and its enable bit were both 1. It rises one clock after a flag latches and falls one clock after the flag is cleared.
- R11: Address 0x11 reads `{5'b0, dpll_mode, lol, los}` (LOS in bit 0, LOL in bit 1, mode in bit 2), and reading it changes nothing. Writes to 0x11 and 0x12 are ignored. Any other address reads 0. Read data appears on `reg_rdata` one clock after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_avail | input | NUM_REFS | Availability of each input reference |
| xref_active | input | 1 | Activity detected on the external reference |
| auto_sel | input | 1 | 1 = automatic reference selection, 0 = manual |
| dpll_mode | input | 1 | Current loop mode indication |
| active_ref | input | clog2(NUM_REFS) | Index of the reference currently in use |
| los | input | 1 | Loss of signal on the active reference |
| lol | input | 1 | Loss of lock on the active reference |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| irq | output | 1 | Interrupt, active high |

## Verification
A vector table steps the status lines through single transitions: a reference dropping and returning, external activity toggling, and a mode change. This shows that each event maps to its own bit and to no other. The table then applies compound switches (switch alone, switch with loss of signal and a lost reference, switch with loss of lock, and a revertive switch on a returning reference), which separates the cause bits that must appear together. It then repeats similar patterns with selection set to manual, which distinguishes flags driven by edges from flags held by a persisting alarm, and confirms that bit 5 stays clear. Directed steps cover the masked event, the interrupt latency, a read that collides with a new event, and the registers that must have no side effects.

// File: rtl/tref_irq_pkg.sv
package tref_irq_pkg;

    localparam int EVT_W = 8;

    // event bit positions (software decodes these)
    localparam int EV_REF_LOST  = 0;
    localparam int EV_REF_BACK  = 1;
    localparam int EV_XREF_DEAD = 2;
    localparam int EV_XREF_LIVE = 3;
    localparam int EV_STAT_CHG  = 4;
    localparam int EV_SWITCH    = 5;
    localparam int EV_LOS       = 6;
    localparam int EV_LOL       = 7;

    // status word bit positions
    localparam int ST_LOS  = 0;
    localparam int ST_LOL  = 1;
    localparam int ST_MODE = 2;
    localparam int ST_W    = 3;

    typedef logic [EVT_W-1:0] evt_vec_t;
    typedef logic [ST_W-1:0]  stat_vec_t;

endpackage

// File: rtl/tref_irq_detect.sv
module tref_irq_detect
    import tref_irq_pkg::*;
#(
    parameter int NUM_REFS = 4,
    parameter int IDX_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REFS-1:0] ref_avail,
    input  logic                xref_active,
    input  logic                auto_sel,
    input  stat_vec_t           stat_now,
    input  logic [IDX_W-1:0]    active_ref,
    output evt_vec_t            raw_evt,
    output logic                armed
);

    typedef struct packed {
        logic                armed;
        logic [NUM_REFS-1:0] avail;
        logic                xref;
        stat_vec_t           stat;
        logic [IDX_W-1:0]    ref_idx;
    } det_state_t;

    det_state_t st_d, st_q;

    logic [NUM_REFS-1:0] lost_vec;
    logic [NUM_REFS-1:0] back_vec;

    // per-reference transition detectors
    for (genvar g = 0; g < NUM_REFS; g++) begin : g_ref_edge
        assign lost_vec[g] = st_q.avail[g] & ~ref_avail[g];
        assign back_vec[g] = ~st_q.avail[g] & ref_avail[g];
    end

    always_comb begin
        logic switched;
        logic stat_moved;

        st_d         = st_q;
        st_d.armed   = 1'b1;
        st_d.avail   = ref_avail;
        st_d.xref    = xref_active;
        st_d.stat    = stat_now;
        st_d.ref_idx = active_ref;

        switched   = (active_ref != st_q.ref_idx);
        stat_moved = (stat_now != st_q.stat) || switched;

        raw_evt = '0;
        if (st_q.armed) begin
            raw_evt[EV_REF_LOST]  = |lost_vec;
            raw_evt[EV_REF_BACK]  = |back_vec;
            raw_evt[EV_XREF_DEAD] = st_q.xref & ~xref_active;
            raw_evt[EV_XREF_LIVE] = ~st_q.xref & xref_active;
            raw_evt[EV_STAT_CHG]  = stat_moved;
            raw_evt[EV_SWITCH]    = auto_sel & switched;
            raw_evt[EV_LOS]       = ~st_q.stat[ST_LOS] & stat_now[ST_LOS];
            raw_evt[EV_LOL]       = ~st_q.stat[ST_LOL] & stat_now[ST_LOL];
            if (!auto_sel) begin
                // manual mode: alarm flags follow the live alarm level
                raw_evt[EV_LOS] = raw_evt[EV_LOS] | stat_now[ST_LOS];
                raw_evt[EV_LOL] = raw_evt[EV_LOL] | stat_now[ST_LOL];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed = st_q.armed;

    // R1: nothing is reported in the cycle that loads the first samples
    assert_quiet_first_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.armed |-> raw_evt == '0);

endmodule

// File: rtl/tref_irq_regs.sv
module tref_irq_regs
    import tref_irq_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  STAT_ADDR = 8'h11,
    parameter logic [7:0]  EVT_ADDR  = 8'h12,
    parameter logic [7:0]  MASK_ADDR = 8'h13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  evt_vec_t          raw_evt,
    input  stat_vec_t         stat_now,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output evt_vec_t          evt_flags,
    output evt_vec_t          mask_flags,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(EVT_ADDR);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);

    typedef struct packed {
        evt_vec_t   evt;
        evt_vec_t   mask;
        logic [7:0] rdata;
        logic       irq;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic evt_read;
    assign evt_read = reg_rd && (reg_addr == A_EVT);

    always_comb begin
        st_d = st_q;

        // read path: value seen before this clock's update
        if (reg_rd) begin
            unique case (reg_addr)
                A_STAT:  st_d.rdata = {{(8-ST_W){1'b0}}, stat_now};
                A_EVT:   st_d.rdata = st_q.evt;
                A_MASK:  st_d.rdata = st_q.mask;
                default: st_d.rdata = 8'h00;
            endcase
        end

        // sticky flags, cleared as a group by a read, new events win
        st_d.evt = (evt_read ? '0 : st_q.evt) | raw_evt;

        if (reg_wr && (reg_addr == A_MASK)) begin
            st_d.mask = reg_wdata;
        end

        st_d.irq = |(st_q.evt & st_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata  = st_q.rdata;
    assign evt_flags  = st_q.evt;
    assign mask_flags = st_q.mask;
    assign irq        = st_q.irq;

    // R8: without a read of the event register no flag ever drops
    assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_read |=> (st_q.evt & $past(st_q.evt)) == $past(st_q.evt));

    // R9: after a clearing read only freshly detected events remain
    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_read |=> (st_q.evt & ~$past(raw_evt)) == '0);

    // R9: the read returns the pre-clear flags
    assert_read_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_read |=> st_q.rdata == $past(st_q.evt));

    // R11: mask only changes through a write to its own address
    assert_mask_write_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == A_MASK) |=> $stable(st_q.mask));

endmodule

// File: rtl/tref_irq_ctrl.sv
module tref_irq_ctrl
    import tref_irq_pkg::*;
#(
    parameter int          NUM_REFS  = 4,
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  STAT_ADDR = 8'h11,
    parameter logic [7:0]  EVT_ADDR  = 8'h12,
    parameter logic [7:0]  MASK_ADDR = 8'h13,
    localparam int         IDX_W     = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REFS-1:0] ref_avail,
    input  logic                xref_active,
    input  logic                auto_sel,
    input  logic                dpll_mode,
    input  logic [IDX_W-1:0]    active_ref,
    input  logic                los,
    input  logic                lol,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    output logic                irq
);

    stat_vec_t stat_now;
    evt_vec_t  raw_evt;
    evt_vec_t  evt_flags;
    evt_vec_t  mask_flags;
    logic      armed;

    always_comb begin
        stat_now          = '0;
        stat_now[ST_LOS]  = los;
        stat_now[ST_LOL]  = lol;
        stat_now[ST_MODE] = dpll_mode;
    end

    tref_irq_detect #(
        .NUM_REFS (NUM_REFS),
        .IDX_W    (IDX_W)
    ) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_avail   (ref_avail),
        .xref_active (xref_active),
        .auto_sel    (auto_sel),
        .stat_now    (stat_now),
        .active_ref  (active_ref),
        .raw_evt     (raw_evt),
        .armed       (armed)
    );

    tref_irq_regs #(
        .ADDR_W    (ADDR_W),
        .STAT_ADDR (STAT_ADDR),
        .EVT_ADDR  (EVT_ADDR),
        .MASK_ADDR (MASK_ADDR)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_evt    (raw_evt),
        .stat_now   (stat_now),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .evt_flags  (evt_flags),
        .mask_flags (mask_flags),
        .irq        (irq)
    );

    // R5: an automatic switch reports both the switch and the status change
    assert_switch_causes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && auto_sel && active_ref != $past(active_ref))
            |=> evt_flags[EV_SWITCH] && evt_flags[EV_STAT_CHG]);

    // R5: the switch flag only appears under automatic selection
    assert_manual_no_switch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_flags[EV_SWITCH]) |-> $past(auto_sel));

    // R7: manual mode keeps the alarm flags set while the alarm lasts
    assert_manual_los_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !auto_sel && los) |=> evt_flags[EV_LOS]);
    assert_manual_lol_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !auto_sel && lol) |=> evt_flags[EV_LOL]);

    // R10: pin is the registered masked OR
    assert_irq_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(evt_flags & mask_flags)));

    // R8: an all-zero mask keeps the pin low
    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_flags == '0 && $past(mask_flags) == '0) |-> !irq);

endmodule

// File: tb/tref_irq_ctrl_bench.sv
`timescale 1ns/1ps
module tref_irq_ctrl_bench;

    localparam int NREF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ref_avail = 4'hF;
    logic       xref_active = 1'b1;
    logic       auto_sel = 1'b1;
    logic       dpll_mode = 1'b1;
    logic [1:0] active_ref = 2'd0;
    logic       los = 1'b0;
    logic       lol = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tref_irq_ctrl #(.NUM_REFS(NREF)) u_tref_irq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_avail   (ref_avail),
        .xref_active (xref_active),
        .auto_sel    (auto_sel),
        .dpll_mode   (dpll_mode),
        .active_ref  (active_ref),
        .los         (los),
        .lol         (lol),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .irq         (irq)
    );

    // vector: avail[18:15] xref[14] auto[13] mode[12] ref[11:10] los[9] lol[8] expected[7:0]
    localparam int NVEC = 16;
    localparam logic [18:0] VEC [NVEC] = '{
        {4'hE, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 8'h01}, // R2 ref lost
        {4'hF, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 8'h02}, // R2 ref back
        {4'hF, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 8'h04}, // R3 xref dead
        {4'hF, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 8'h08}, // R3 xref live
        {4'hF, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 8'h10}, // R4 mode change
        {4'hF, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 8'h30}, // R5 plain switch
        {4'hB, 1'b1, 1'b1, 1'b0, 2'd2, 1'b1, 1'b0, 8'h71}, // R6 switch on LOS
        {4'hB, 1'b1, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 8'h10}, // R4 LOS clears
        {4'hB, 1'b1, 1'b1, 1'b0, 2'd3, 1'b0, 1'b1, 8'hB0}, // R6 switch on LOL
        {4'hF, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 8'h32}, // R6 revertive switch
        {4'hF, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 8'h00}, // R5 enter manual
        {4'hF, 1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 8'h50}, // R7 manual LOS
        {4'hF, 1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 8'h40}, // R7 LOS persists
        {4'hF, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 8'hD0}, // R7 manual LOL
        {4'hF, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 8'h90}, // R7 LOL clears
        {4'hF, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'h10}  // R5 manual ref change
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // called at a negedge, returns at the next negedge with data valid
    task automatic rd_reg(input logic [7:0] addr, output logic [7:0] data);
        reg_addr = addr;
        reg_rd   = 1'b1;
        @(negedge clk);
        reg_rd   = 1'b0;
        data     = reg_rdata;
    endtask

    task automatic wr_reg(input logic [7:0] addr, input logic [7:0] data);
        reg_addr  = addr;
        reg_wdata = data;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;

        // R1: reset with nonzero inputs present
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", {7'd0, irq}, 8'h00);
        @(negedge clk);
        rd_reg(8'h12, d);
        check("R1 no false events", d, 8'h00);
        rd_reg(8'h13, d);
        check("R1 mask reset", d, 8'h00);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            ref_avail   = VEC[i][18:15];
            xref_active = VEC[i][14];
            auto_sel    = VEC[i][13];
            dpll_mode   = VEC[i][12];
            active_ref  = VEC[i][11:10];
            los         = VEC[i][9];
            lol         = VEC[i][8];
            @(negedge clk);
            rd_reg(8'h12, d);
            check($sformatf("vector %0d (R2..R7)", i), d, VEC[i][7:0]);
        end

        // R11: status read has no side effects
        auto_sel  = 1'b1;
        los       = 1'b1;
        dpll_mode = 1'b1;
        @(negedge clk);
        rd_reg(8'h11, d);
        check("R11 status word", d, 8'h05);
        rd_reg(8'h11, d);
        check("R11 status reread", d, 8'h05);
        rd_reg(8'h12, d);
        check("R11 events survive status read", d, 8'h50);
        los       = 1'b0;
        dpll_mode = 1'b0;
        @(negedge clk);
        rd_reg(8'h12, d);
        check("R4 status restore", d, 8'h10);

        // R8/R11: mask access, ignored writes, unknown address
        wr_reg(8'h13, 8'h04);
        rd_reg(8'h13, d);
        check("R8 mask readback", d, 8'h04);
        wr_reg(8'h11, 8'hFF);
        wr_reg(8'h12, 8'hFF);
        rd_reg(8'h12, d);
        check("R11 writes ignored", d, 8'h00);
        rd_reg(8'h20, d);
        check("R11 unknown address", d, 8'h00);

        // R8: disabled event latches but keeps irq low
        ref_avail = 4'hE;
        @(negedge clk);
        @(negedge clk);
        check("R8 masked irq", {7'd0, irq}, 8'h00);
        rd_reg(8'h12, d);
        check("R8 masked event latched", d, 8'h01);
        ref_avail = 4'hF;
        @(negedge clk);
        rd_reg(8'h12, d);

        // R10: irq latency on an enabled event
        xref_active = 1'b0;
        @(negedge clk);
        check("R10 irq one cycle late", {7'd0, irq}, 8'h00);
        @(negedge clk);
        check("R10 irq raised", {7'd0, irq}, 8'h01);
        rd_reg(8'h12, d);
        check("R9 read value", d, 8'h04);
        check("R10 irq held through clear edge", {7'd0, irq}, 8'h01);
        @(negedge clk);
        check("R10 irq dropped", {7'd0, irq}, 8'h00);

        // R9: event in the same clock as the clearing read
        xref_active = 1'b1;
        rd_reg(8'h12, d);
        check("R9 read before collision", d, 8'h00);
        rd_reg(8'h12, d);
        check("R9 colliding event kept", d, 8'h08);
        rd_reg(8'h12, d);
        check("R9 cleared afterwards", d, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule